// File: doc/BRIEF.md
# Audio TDM Clock and Frame-Sync Generator

This block produces the timing for a serial audio port: a host clock, a serial bit clock and a frame-sync. It also produces single-cycle strobes that mark bit, slot and frame boundaries for the serializers next to it. Everything runs in one system clock domain. The host clock source is a one-cycle tick input, `src_tick`, or the rising edges of an external pin. Each derived clock is held as a level that changes only on those ticks. Framing can be two-channel I2S, left-justified or multi-slot TDM.

Two dividers turn the source into the host clock and then into the bit clock. Each 6-bit divider field divides by its value plus one. A frame holds one to eight slots of 8, 16, 24 or 32 bits. The frame-sync pulse can be one slot wide, half a frame wide or one bit wide. In burst mode it becomes a single one-bit pulse that is issued only on request. External pins can replace the host clock source, the bit clock and the frame-sync. Each output has its own inversion control, and a separate inversion applies to the external frame-sync before the framing logic uses it.

Clearing `enable` stops the block. All divider and framing counters return to zero, the outputs settle at their inactive levels, and any waiting burst request is dropped.

Top module: `tdm_clkgen`

## Requirements
- R1: The host clock period is (host_div+1) source ticks. The host clock level is high for the first ceil((host_div+1)/2) ticks of each period. The first tick after enable starts a period.
- R2: With the internal bit clock, a bit period is (ser_div+1) host periods. The serial clock is high for the first ceil((ser_div+1)/2) host periods of each bit. bit_stb pulses for one cycle at the start of every bit period. All outputs are registered, so each one appears in the cycle after the tick that causes it.
- R3: slot_size codes 0, 1, 2 and 3 give 8, 16, 24 and 32 bits per slot. A frame holds slot_cnt+1 slots. After enable, framing starts at bit 0 of slot 0.
- R4: fs_width code 0 holds the internal frame-sync high for all of slot 0. Code 1 holds it high for the first floor(frame bits/2) bits. Code 2 holds it high for bit 0 only. The internal frame-sync changes only on bit ticks.
- R5: With data_delay=0, slot_stb marks bit 0 of each slot and frame_stb marks bit 0 of slot 0. With data_delay=1, both strobes come one bit period later.
- R6: fs_width code 3 selects burst mode. In burst mode, no frame-sync pulse, slot_stb or frame_stb appears without a request, while bit_stb keeps running. A burst_req pulse causes a one-bit frame-sync pulse on the next free bit tick, which starts one slot-long transfer. A request made during a transfer waits until that transfer ends.
- R7: host_out_inv, ser_out_inv and fs_out_inv each invert their own output.
- R8: With host_src_ext=1, each rising edge of ext_host_pin replaces src_tick as the host source tick.
- R9: With ser_src_ext=1, each rising edge of ext_ser_pin is a bit tick, and ser_clk_o follows ext_ser_pin one cycle later.
- R10: With fs_src_ext=1, the frame-sync output follows ext_fs_pin one cycle later. A rising edge of (ext_fs_pin XOR fs_in_inv) seen at a bit tick restarts framing at bit 0 of slot 0.
- R11: While enable is low, counters are cleared, the strobes are 0, each clock and sync output equals its own inversion bit, and a waiting burst request is dropped.
- R12: frame_stb is only ever high together with slot_stb, and slot_stb only together with bit_stb.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs division and framing; clearing it resets the unit |
| src_tick | input | 1 | Internal host source tick, one cycle per source period |
| host_src_ext | input | 1 | Use edges of ext_host_pin as the host source |
| ext_host_pin | input | 1 | External host clock pin level |
| host_div | input | 6 | Host divider, divides the source by value+1 |
| host_out_inv | input | 1 | Invert host clock output |
| ser_div | input | 6 | Bit-clock divider, divides the host clock by value+1 |
| ser_src_ext | input | 1 | Use ext_ser_pin as the bit clock |
| ext_ser_pin | input | 1 | External bit clock pin level |
| ser_out_inv | input | 1 | Invert serial clock output |
| fs_src_ext | input | 1 | Use ext_fs_pin as the frame-sync |
| ext_fs_pin | input | 1 | External frame-sync pin level |
| fs_in_inv | input | 1 | Invert external frame-sync before framing uses it |
| fs_out_inv | input | 1 | Invert frame-sync output |
| data_delay | input | 1 | 0: no delay, 1: one bit delay of the data strobes |
| fs_width | input | 2 | 0 slot, 1 half frame, 2 one bit, 3 burst |
| slot_cnt | input | 3 | Slots per frame minus one |
| slot_size | input | 2 | Slot size code: 8, 16, 24 or 32 bits |
| burst_req | input | 1 | Transfer request pulse in burst mode |
| host_clk_o | output | 1 | Host clock level |
| ser_clk_o | output | 1 | Serial clock level |
| fs_o | output | 1 | Frame-sync level |
| bit_stb | output | 1 | Start of a bit period |
| slot_stb | output | 1 | First data bit of a slot |
| frame_stb | output | 1 | First data bit of a frame |

## Verification
The hardest case to reach from the ports is a burst request that is still waiting when the unit is disabled. With divider settings of 1, a request is consumed on the very next edge, so the window never opens. The stimulus therefore slows the bit clock to one tick every four cycles, raises a request between ticks, and drops enable before the next tick. After re-enabling, it watches that no frame-sync pulse appears. Frame restarts driven by the external frame-sync are reached by raising that pin in the middle of a frame and checking that the frame strobe jumps to that bit.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    localparam int DIV_W         = 6;
    localparam int SLOT_CNT_W    = 3;
    localparam int MAX_SLOT_BITS = 32;
    localparam int MAX_SLOTS     = 1 << SLOT_CNT_W;
    localparam int BIT_W         = $clog2(MAX_SLOT_BITS);
    localparam int POS_W         = $clog2(MAX_SLOT_BITS * MAX_SLOTS) + 1;

    typedef enum logic [1:0] {
        FSW_SLOT  = 2'd0,
        FSW_HALF  = 2'd1,
        FSW_BIT   = 2'd2,
        FSW_BURST = 2'd3
    } fsw_e;

    typedef struct packed {
        logic slot_s;
        logic frame_s;
    } bound_t;

    typedef struct packed {
        logic bit_s;
        logic slot_s;
        logic frame_s;
    } strobe_t;

    // bits per slot for a 2-bit size code: 8 * (code + 1)
    function automatic logic [BIT_W:0] slot_bits(input logic [1:0] code);
        return {1'b0, code, 3'b000} + (BIT_W + 1)'(8);
    endfunction

endpackage

// File: rtl/tdm_tick_div.sv
module tdm_tick_div #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         tick_i,
    input  logic [W-1:0] div_i,
    output logic         tick_o,
    output logic         lvl_o
);
    logic [W-1:0] cnt_q;
    logic [W:0]   half;

    // ceil((div+1)/2) ticks of high time
    assign half   = ({1'b0, div_i} + (W + 1)'(2)) >> 1;
    assign tick_o = tick_i && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
            lvl_o <= 1'b0;
        end else if (tick_i) begin
            lvl_o <= ({1'b0, cnt_q} < half);
            cnt_q <= (cnt_q >= div_i) ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/tdm_framer.sv
module tdm_framer
    import tdm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  bit_t,
    input  logic [1:0]            fs_width,
    input  logic [SLOT_CNT_W-1:0] slot_cnt,
    input  logic [1:0]            slot_size,
    input  logic                  data_delay,
    input  logic                  ext_fs_sel,
    input  logic                  ext_fs_used,
    input  logic                  burst_req,
    output logic                  fs_int,
    output strobe_t               stb_o
);
    logic [BIT_W-1:0]      bcnt_q, cur_b;
    logic [SLOT_CNT_W-1:0] slcnt_q, cur_s;
    logic [BIT_W:0]        sbits;
    logic [POS_W-1:0]      total, pos;
    logic                  fsu_q, pend_q, act_q;
    logic                  burst, resync, start, idle;
    logic                  last_b, last_s, fs_calc;
    bound_t                now_b, dly_q;
    fsw_e                  wmode;

    assign wmode  = fsw_e'(fs_width);
    assign sbits  = slot_bits(slot_size);
    assign total  = POS_W'(sbits) * (POS_W'(slot_cnt) + POS_W'(1));
    assign burst  = !ext_fs_sel && (wmode == FSW_BURST);
    assign resync = ext_fs_sel && ext_fs_used && !fsu_q;
    assign start  = burst && !act_q && pend_q;
    assign idle   = burst && !act_q && !pend_q;
    assign cur_b  = resync ? '0 : bcnt_q;
    assign cur_s  = resync ? '0 : slcnt_q;
    assign pos    = POS_W'(cur_s) * POS_W'(sbits) + POS_W'(cur_b);
    assign last_b = ({1'b0, cur_b} == sbits - 1'b1);
    assign last_s = (cur_s == slot_cnt);

    assign now_b.slot_s  = (cur_b == '0);
    assign now_b.frame_s = (cur_b == '0) && (cur_s == '0);

    always_comb begin
        unique case (wmode)
            FSW_SLOT:  fs_calc = (cur_s == '0);
            FSW_HALF:  fs_calc = (pos < (total >> 1));
            FSW_BIT:   fs_calc = (pos == '0);
            default:   fs_calc = start;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            bcnt_q  <= '0;
            slcnt_q <= '0;
            fsu_q   <= 1'b0;
            pend_q  <= 1'b0;
            act_q   <= 1'b0;
            fs_int  <= 1'b0;
            dly_q   <= '0;
            stb_o   <= '0;
        end else begin
            pend_q <= (pend_q && !(bit_t && start)) || (burst_req && burst);
            if (bit_t) begin
                fsu_q       <= ext_fs_used;
                stb_o.bit_s <= 1'b1;
                if (idle) begin
                    fs_int        <= 1'b0;
                    dly_q         <= '0;
                    stb_o.slot_s  <= 1'b0;
                    stb_o.frame_s <= 1'b0;
                end else begin
                    bcnt_q  <= last_b ? '0 : cur_b + 1'b1;
                    slcnt_q <= !last_b ? cur_s :
                               ((last_s || burst) ? '0 : cur_s + 1'b1);
                    if (burst) act_q <= !last_b;
                    fs_int <= fs_calc;
                    dly_q  <= now_b;
                    if (data_delay) begin
                        stb_o.slot_s  <= dly_q.slot_s;
                        stb_o.frame_s <= dly_q.frame_s;
                    end else begin
                        stb_o.slot_s  <= now_b.slot_s;
                        stb_o.frame_s <= now_b.frame_s;
                    end
                end
            end else begin
                stb_o <= '0;
            end
        end
    end
endmodule

// File: rtl/tdm_clkgen.sv
module tdm_clkgen
    import tdm_pkg::*;
#(
    parameter int HDIV_W = DIV_W,
    parameter int SDIV_W = DIV_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  enable,
    input  logic                  src_tick,
    input  logic                  host_src_ext,
    input  logic                  ext_host_pin,
    input  logic [HDIV_W-1:0]     host_div,
    input  logic                  host_out_inv,
    input  logic [SDIV_W-1:0]     ser_div,
    input  logic                  ser_src_ext,
    input  logic                  ext_ser_pin,
    input  logic                  ser_out_inv,
    input  logic                  fs_src_ext,
    input  logic                  ext_fs_pin,
    input  logic                  fs_in_inv,
    input  logic                  fs_out_inv,
    input  logic                  data_delay,
    input  logic [1:0]            fs_width,
    input  logic [SLOT_CNT_W-1:0] slot_cnt,
    input  logic [1:0]            slot_size,
    input  logic                  burst_req,
    output logic                  host_clk_o,
    output logic                  ser_clk_o,
    output logic                  fs_o,
    output logic                  bit_stb,
    output logic                  slot_stb,
    output logic                  frame_stb
);
    logic    clr;
    logic    host_pin_q, ser_pin_q, fs_pin_q;
    logic    src_t, host_tick, host_lvl;
    logic    ser_tick_int, ser_lvl_int, bit_t;
    logic    fs_int;
    strobe_t stb;

    assign clr = !enable;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            host_pin_q <= 1'b0;
            ser_pin_q  <= 1'b0;
            fs_pin_q   <= 1'b0;
        end else begin
            host_pin_q <= ext_host_pin;
            ser_pin_q  <= ext_ser_pin;
            fs_pin_q   <= ext_fs_pin;
        end
    end

    assign src_t = host_src_ext ? (ext_host_pin && !host_pin_q) : src_tick;

    tdm_tick_div #(.W(HDIV_W)) u_host_div (
        .clk(clk), .rst(rst), .clr(clr), .tick_i(src_t), .div_i(host_div),
        .tick_o(host_tick), .lvl_o(host_lvl)
    );

    tdm_tick_div #(.W(SDIV_W)) u_ser_div (
        .clk(clk), .rst(rst), .clr(clr), .tick_i(host_tick), .div_i(ser_div),
        .tick_o(ser_tick_int), .lvl_o(ser_lvl_int)
    );

    assign bit_t = enable && (ser_src_ext ? (ext_ser_pin && !ser_pin_q) : ser_tick_int);

    tdm_framer u_framer (
        .clk(clk), .rst(rst), .clr(clr), .bit_t(bit_t),
        .fs_width(fs_width), .slot_cnt(slot_cnt), .slot_size(slot_size),
        .data_delay(data_delay), .ext_fs_sel(fs_src_ext),
        .ext_fs_used(ext_fs_pin ^ fs_in_inv), .burst_req(burst_req),
        .fs_int(fs_int), .stb_o(stb)
    );

    assign host_clk_o = host_lvl ^ host_out_inv;
    assign ser_clk_o  = (ser_src_ext ? ser_pin_q : ser_lvl_int) ^ ser_out_inv;
    assign fs_o       = (fs_src_ext ? fs_pin_q : fs_int) ^ fs_out_inv;
    assign bit_stb    = stb.bit_s;
    assign slot_stb   = stb.slot_s;
    assign frame_stb  = stb.frame_s;
endmodule

// File: rtl/tdm_clkgen_chk.sv
module tdm_clkgen_chk (
    input logic       clk,
    input logic       rst,
    input logic       enable,
    input logic       host_out_inv,
    input logic       ser_out_inv,
    input logic       fs_src_ext,
    input logic       fs_out_inv,
    input logic       data_delay,
    input logic [1:0] fs_width,
    input logic       host_clk_o,
    input logic       ser_clk_o,
    input logic       fs_o,
    input logic       bit_stb,
    input logic       slot_stb,
    input logic       frame_stb
);
    a_r12_frame_in_slot: assert property (@(posedge clk) disable iff (rst)
        frame_stb |-> slot_stb);

    a_r12_slot_in_bit: assert property (@(posedge clk) disable iff (rst)
        slot_stb |-> bit_stb);

    a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!bit_stb && !slot_stb && !frame_stb
                     && (host_clk_o == host_out_inv)
                     && (ser_clk_o == ser_out_inv)));

    a_r4_fs_moves_on_bit: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(enable) && !fs_src_ext && $stable(fs_src_ext)
         && $stable(fs_out_inv) && !$stable(fs_o)) |-> bit_stb);

    a_r6_burst_pulse_starts_frame: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(enable) && fs_width == 2'd3 && $stable(fs_width)
         && !fs_src_ext && $stable(fs_src_ext) && !data_delay
         && $stable(data_delay) && $stable(fs_out_inv)
         && $rose(fs_o ^ fs_out_inv)) |-> frame_stb);
endmodule

bind tdm_clkgen tdm_clkgen_chk u_chk (.*);

// File: tb/tdm_clkgen_tb.sv
module tdm_clkgen_tb;
    logic clk = 1'b0, rst = 1'b1, enable = 1'b0;
    logic src_tick = 1'b1, host_src_ext = 1'b0, ext_host_pin = 1'b0;
    logic [5:0] host_div = '0, ser_div = '0;
    logic host_out_inv = 1'b0, ser_src_ext = 1'b0, ext_ser_pin = 1'b0, ser_out_inv = 1'b0;
    logic fs_src_ext = 1'b0, ext_fs_pin = 1'b0, fs_in_inv = 1'b0, fs_out_inv = 1'b0;
    logic data_delay = 1'b0, burst_req = 1'b0;
    logic [1:0] fs_width = '0, slot_size = '0;
    logic [2:0] slot_cnt = '0;
    logic host_clk_o, ser_clk_o, fs_o, bit_stb, slot_stb, frame_stb;
    int checks = 0, errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    tdm_clkgen u_dut (.*);

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    // expected outputs with src_tick held high, enable raised just before edge c=0
    task automatic compare(input int c);
        int d1, m1, p, n, sb, tot, pos, dpos, efs;
        bit bt, valid;
        d1 = host_div + 1; m1 = ser_div + 1; p = d1 * m1;
        n = c / p; sb = (slot_size + 1) * 8; tot = sb * (slot_cnt + 1);
        pos = n % tot; bt = (c % p) == 0;
        valid = data_delay ? (n >= 1) : 1'b1;
        dpos = data_delay ? ((n + tot - 1) % tot) : pos;
        case (fs_width)
            2'd0: efs = (pos < sb);
            2'd1: efs = (pos < tot / 2);
            default: efs = (pos == 0);
        endcase
        check("R1 host clock", host_clk_o, int'(((c % d1) < (d1 + 1) / 2) ^ host_out_inv));
        check("R2 serial clock", ser_clk_o, int'((((c / d1) % m1) < (m1 + 1) / 2) ^ ser_out_inv));
        check("R2 bit strobe", bit_stb, int'(bt));
        check("R4 frame sync", fs_o, efs ^ int'(fs_out_inv));
        check("R5 slot strobe (R3 geometry)", slot_stb, int'(bt && valid && (dpos % sb == 0)));
        check("R5 frame strobe (R3 geometry)", frame_stb, int'(bt && valid && dpos == 0));
    endtask

    task automatic run_cfg(input int ncyc);
        enable = 1'b1;
        for (int c = 0; c < ncyc; c++) begin
            cyc();
            compare(c);
        end
        enable = 1'b0;
        cyc();
    endtask

    initial begin
        int last, fs_cnt;
        cyc(); cyc();
        // reset state
        check("R11 reset host", host_clk_o, 0);
        check("R11 reset ser", ser_clk_o, 0);
        check("R11 reset fs", fs_o, 0);
        check("R11 reset strobes", {bit_stb, slot_stb, frame_stb}, 0);
        host_out_inv = 1; ser_out_inv = 1; fs_out_inv = 1;
        #1;
        check("R7 inverted idle host", host_clk_o, 1);
        check("R7 inverted idle ser", ser_clk_o, 1);
        check("R7 inverted idle fs", fs_o, 1);
        host_out_inv = 0; ser_out_inv = 0; fs_out_inv = 0;
        rst = 1'b0;
        cyc();

        // R3 R4 R5: framing sweep with unit dividers
        for (int sz = 0; sz < 4; sz++)
            for (int ns = 0; ns < 8; ns++)
                for (int w = 0; w < 3; w++)
                    for (int dd = 0; dd < 2; dd++) begin
                        slot_size = 2'(sz); slot_cnt = 3'(ns);
                        fs_width = 2'(w); data_delay = dd[0];
                        run_cfg((sz + 1) * 8 * (ns + 1) + 3);
                    end

        // R1 R2 R7: divider sweep, inversions varied
        for (int d = 0; d < 4; d++)
            for (int m = 0; m < 4; m++) begin
                host_div = 6'(d); ser_div = 6'(m);
                slot_size = 2'd0; slot_cnt = 3'd1; fs_width = 2'd1; data_delay = 1'b1;
                host_out_inv = d[0]; ser_out_inv = m[0]; fs_out_inv = d[1] ^ m[0];
                run_cfg(17 * (d + 1) * (m + 1) + 2);
            end
        host_div = '0; ser_div = '0;
        host_out_inv = 0; ser_out_inv = 0; fs_out_inv = 0;

        // R6: burst mode, request handling
        fs_width = 2'd3; slot_size = 2'd0; slot_cnt = 3'd3; data_delay = 1'b0;
        enable = 1'b1;
        fs_cnt = 0;
        for (int i = 0; i < 12; i++) begin
            cyc();
            fs_cnt += int'(fs_o) + int'(slot_stb) + int'(frame_stb);
            check("R6 burst bit strobe runs", bit_stb, 1);
        end
        check("R6 no pulse without request", fs_cnt, 0);
        burst_req = 1'b1;
        cyc();
        burst_req = 1'b0;
        check("R6 request edge no pulse yet", fs_o, 0);
        cyc();
        check("R6 burst fs pulse", fs_o, 1);
        check("R6 burst frame strobe", frame_stb, 1);
        check("R6 burst slot strobe", slot_stb, 1);
        fs_cnt = 0;
        for (int i = 2; i <= 8; i++) begin
            if (i == 5) burst_req = 1'b1;
            cyc();
            burst_req = 1'b0;
            fs_cnt += int'(fs_o);
        end
        check("R6 queued request waits", fs_cnt, 0);
        cyc();
        check("R6 queued pulse after transfer", fs_o, 1);
        fs_cnt = 0;
        for (int i = 0; i < 20; i++) begin
            cyc();
            fs_cnt += int'(fs_o) + int'(slot_stb);
        end
        check("R6 one pulse per request", fs_cnt, 0);
        enable = 1'b0;
        cyc();

        // R11: waiting request dropped by disable
        ser_div = 6'd3;
        enable = 1'b1;
        cyc();
        burst_req = 1'b1;
        cyc();
        burst_req = 1'b0;
        enable = 1'b0;
        cyc();
        enable = 1'b1;
        fs_cnt = 0;
        for (int i = 0; i < 24; i++) begin
            cyc();
            fs_cnt += int'(fs_o);
        end
        check("R11 pending request dropped", fs_cnt, 0);
        enable = 1'b0;
        ser_div = '0;
        cyc();

        // R8: external host source edges, period 6 cycles
        host_src_ext = 1'b1; fs_width = 2'd2; slot_cnt = 3'd0;
        enable = 1'b1;
        last = -1;
        for (int i = 0; i < 48; i++) begin
            ext_host_pin = ((i % 6) < 3);
            cyc();
            if (bit_stb) begin
                if (last >= 0) check("R8 external host tick spacing", i - last, 6);
                else check("R8 first external tick", i, 0);
                last = i;
            end
        end
        enable = 1'b0; host_src_ext = 1'b0; ext_host_pin = 1'b0;
        cyc();

        // R9: external serial clock pin
        ser_src_ext = 1'b1; ser_out_inv = 1'b1;
        enable = 1'b1;
        for (int i = 0; i < 24; i++) begin
            logic prev;
            prev = ext_ser_pin;
            ext_ser_pin = ((i % 4) < 2);
            cyc();
            check("R9 serial clock follows pin", ser_clk_o, int'(ext_ser_pin ^ 1'b1));
            check("R9 bit tick on pin rise", bit_stb, int'(ext_ser_pin && !prev));
        end
        enable = 1'b0; ser_src_ext = 1'b0; ser_out_inv = 1'b0; ext_ser_pin = 1'b0;
        cyc();

        // R10: external frame sync restarts framing
        fs_src_ext = 1'b1; slot_size = 2'd0; slot_cnt = 3'd1; data_delay = 1'b0;
        for (int inv = 0; inv < 2; inv++) begin
            fs_in_inv = inv[0];
            ext_fs_pin = inv[0];
            enable = 1'b1;
            for (int c = 0; c < 30; c++) begin
                if (c == 5) ext_fs_pin = !inv[0];
                cyc();
                check("R10 frame strobe follows pin", frame_stb, int'(c == 0 || c == 5 || c == 21));
                check("R10 fs output is pin", fs_o, int'(ext_fs_pin));
            end
            enable = 1'b0;
            cyc();
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule